// File: doc/BRIEF.md
# DAC power-up configuration sequencer

This block takes a multichannel DAC from an unknown state to a known default setup over a serial link, with no help from software. A single start pulse begins the run. The first step is a reset. When a reset pin is wired (`has_rst_pin` high), the block pulses that pin. When it is not, the block sends a software reset frame. After the reset it waits a settling gap and then sends a fixed list of configuration frames. The last frame always carries the output span code. When that frame has finished, the block raises `done` and holds it.

Each frame is one chip-select window of 24 bits. The first 8 bits are a command byte and the other 16 are data, sent most-significant bit first. SCLK idles low, and the DAC samples MOSI on the rising edge. The block also keeps three minimum spacings: the reset pulse width, the wait after a reset, and the chip-select high time between frames. Each spacing and the SCLK half-period is a parameter counted in system clock cycles.

Top module: `dacinit_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released until a start is accepted, `cs_n`=1, `sclk`=0, `dac_rst`=0, `done`=0 and `busy`=0.
- R2: With `has_rst_pin`=1 at start, `dac_rst` is high for exactly RST_PULSE_CYC cycles. No frame is sent during that time, and no software reset frame is sent at any point in the run.
- R3: With `has_rst_pin`=0 at start, the first frame is the software reset frame 0x701234 (command 0x70, data 0x1234).
- R4: After the reset ends, `cs_n` stays high for at least POST_RST_CYC cycles before the next frame starts. For the pin reset this counts from the falling edge of `dac_rst`. For the software reset it counts from the rising edge of `cs_n` at the end of the reset frame.
- R5: After the reset, the frames are sent in this order, as {command, data}: 0x51FFFF, 0x905555, 0xA05555, 0xC00000, 0xD00000, 0xB00000. The 0x5555 word has bit 2n set for each channel n from 0 to 7.
- R6: Each frame holds `cs_n` low for exactly 24 SCLK rising edges, with the command byte first and every field MSB first. SCLK changes level every CLK_DIV cycles, MOSI changes only while SCLK is low, and SCLK stays low whenever `cs_n` is high.
- R7: The last frame of every run is the span frame: command 0x40, and data equal to the `span_code` captured at start, in data bits [2:0] with bits [15:3] zero. It is sent only after the reset of the same run.
- R8: Between two frames of the same run, `cs_n` stays high for at least CS_GAP_CYC cycles.
- R9: `done` rises exactly one cycle after `cs_n` rises at the end of the span frame. It stays high until the next accepted start. `busy` is high from the cycle after an accepted start until `done` rises, and `busy` and `done` are never high together.
- R10: A `start` pulse while `busy` is high is ignored. The frame stream, the reset pin and the captured span are unchanged, and no second reset happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the power-up sequence |
| has_rst_pin | input | 1 | 1 = pulse the reset pin, 0 = send the software reset frame |
| span_code | input | 3 | Output span code written by the last frame |
| sclk | output | 1 | Serial clock to the DAC, idle low |
| mosi | output | 1 | Serial data to the DAC |
| cs_n | output | 1 | Active-low chip select, low for one frame |
| dac_rst | output | 1 | Active-high drive for the DAC reset pin |
| done | output | 1 | Sequence finished; held until the next start |
| busy | output | 1 | Sequence in progress |

## Verification
The embedded assertions check the following on every cycle: SCLK idle while deselected, MOSI stable while SCLK is high, 24 rising edges per frame, the reset pulse width, the post-reset and inter-frame chip-select spacing, the span frame being sent only after a reset, `done` following the end of a frame, and a busy start leaving the frame index and the captured span untouched. Other behaviour is visible only at the pins, so the bench's scenarios cover it. They compare the exact frame contents and order against a queue for both reset modes and several span codes. They measure `done` timing against the last chip-select rise. They confirm that a start injected mid-run adds no frame and no extra reset pulse.

// File: rtl/dacinit_pkg.sv
package dacinit_pkg;

  localparam int FRAME_W   = 24;
  localparam int CMD_W     = 8;
  localparam int DATA_W    = 16;
  localparam int DITHER_CH = 8;
  localparam int SPAN_W    = 3;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [2:0]         fidx_t;

  localparam fidx_t FIDX_SWRST = 3'd0;
  localparam fidx_t FIDX_SPAN  = 3'd7;

  function automatic int umax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // one select bit per channel, low bit of each 2-bit slot
  function automatic logic [DATA_W-1:0] dither_src_word();
    logic [DATA_W-1:0] w;
    w = '0;
    for (int n = 0; n < DITHER_CH; n++) w[2*n] = 1'b1;
    return w;
  endfunction

  function automatic frame_t make_frame(input logic [CMD_W-1:0] cmd,
                                        input logic [DATA_W-1:0] dat);
    return {cmd, dat};
  endfunction

  function automatic frame_t frame_for(input fidx_t idx,
                                       input logic [SPAN_W-1:0] span);
    case (idx)
      3'd0:    return make_frame(8'h70, 16'h1234);
      3'd1:    return make_frame(8'h51, 16'hFFFF);
      3'd2:    return make_frame(8'h90, dither_src_word());
      3'd3:    return make_frame(8'hA0, dither_src_word());
      3'd4:    return make_frame(8'hC0, 16'h0000);
      3'd5:    return make_frame(8'hD0, 16'h0000);
      3'd6:    return make_frame(8'hB0, 16'h0000);
      default: return make_frame(8'h40, {{(DATA_W-SPAN_W){1'b0}}, span});
    endcase
  endfunction

endpackage

// File: rtl/dacinit_tx.sv
module dacinit_tx
  import dacinit_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  frame_t word,
  output logic   sclk,
  output logic   mosi,
  output logic   cs_n,
  output logic   fin
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int BIT_W = $clog2(FRAME_W + 1);

  frame_t           shreg;
  logic [DIV_W-1:0] divc;
  logic [BIT_W-1:0] bitc;

  wire half_tick = !cs_n && (divc == DIV_W'(CLK_DIV - 1));
  wire sclk_rise = half_tick && !sclk;
  wire last_bit  = (bitc == BIT_W'(FRAME_W - 1));

  assign mosi = shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      sclk  <= 1'b0;
      shreg <= '0;
      divc  <= '0;
      bitc  <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (cs_n) begin
        if (go) begin
          cs_n  <= 1'b0;
          sclk  <= 1'b0;
          shreg <= word;
          divc  <= '0;
          bitc  <= '0;
        end
      end else if (half_tick) begin
        divc <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (last_bit) begin
            cs_n <= 1'b1;
            fin  <= 1'b1;
          end else begin
            bitc  <= bitc + 1'b1;
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        divc <= divc + 1'b1;
      end
    end
  end

  // checker state: rising edges seen in the current frame
  logic [BIT_W:0] rise_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rise_cnt <= '0;
    else if (cs_n && go)      rise_cnt <= '0;
    else if (sclk_rise)       rise_cnt <= rise_cnt + 1'b1;
  end

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  p_edge_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rise_cnt == (BIT_W+1)'(FRAME_W)));

endmodule

// File: rtl/dacinit_ctl.sv
module dacinit_ctl
  import dacinit_pkg::*;
#(
  parameter int RST_PULSE_CYC = 10,
  parameter int POST_RST_CYC  = 3,
  parameter int CS_GAP_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              has_rst_pin,
  input  logic [SPAN_W-1:0] span_code,
  input  logic              tx_fin,
  output logic              tx_go,
  output frame_t            tx_word,
  output logic              dac_rst,
  output logic              done,
  output logic              busy,
  output logic              rst_done
);
  localparam int SW_GAP = umax(POST_RST_CYC, CS_GAP_CYC);
  localparam int MAXV   = umax(RST_PULSE_CYC, SW_GAP);
  localparam int CNT_W  = $clog2(MAXV + 1);

  typedef enum logic [2:0] {S_IDLE, S_PIN, S_GAP, S_SEND, S_WAIT} st_t;

  st_t               st;
  fidx_t             idx;
  logic [CNT_W-1:0]  cnt;
  logic [SPAN_W-1:0] span_q;

  wire pin_last   = (st == S_PIN) && (cnt == CNT_W'(RST_PULSE_CYC - 1));
  wire frame_end  = (st == S_WAIT) && tx_fin;
  wire last_frame = frame_end && (idx == FIDX_SPAN);

  assign rst_done = pin_last || (frame_end && (idx == FIDX_SWRST));
  assign busy     = (st != S_IDLE);
  assign tx_go    = (st == S_SEND);
  assign tx_word  = frame_for(idx, span_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      cnt     <= '0;
      span_q  <= '0;
      dac_rst <= 1'b0;
      done    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done   <= 1'b0;
          span_q <= span_code;
          if (has_rst_pin) begin
            st      <= S_PIN;
            dac_rst <= 1'b1;
            cnt     <= '0;
            idx     <= fidx_t'(FIDX_SWRST + 3'd1);
          end else begin
            st  <= S_SEND;
            idx <= FIDX_SWRST;
          end
        end
        S_PIN: begin
          if (pin_last) begin
            dac_rst <= 1'b0;
            cnt     <= CNT_W'(POST_RST_CYC - 1);
            st      <= S_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == '0) st <= S_SEND;
          else           cnt <= cnt - 1'b1;
        end
        S_SEND: st <= S_WAIT;
        default: begin
          if (last_frame) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else if (frame_end) begin
            cnt <= (idx == FIDX_SWRST) ? CNT_W'(SW_GAP - 1) : CNT_W'(CS_GAP_CYC - 1);
            idx <= idx + 1'b1;
            st  <= S_GAP;
          end
        end
      endcase
    end
  end

  // checker state: reset pin width and reset-before-span tracking
  logic [CNT_W:0] pin_hi_cnt;
  logic           reset_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hi_cnt <= '0;
      reset_seen <= 1'b0;
    end else begin
      pin_hi_cnt <= dac_rst ? pin_hi_cnt + 1'b1 : '0;
      if (!busy)         reset_seen <= 1'b0;
      else if (rst_done) reset_seen <= 1'b1;
    end
  end

  p_pin_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_rst) |-> (pin_hi_cnt >= (CNT_W+1)'(RST_PULSE_CYC)));
  p_span_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && (idx == FIDX_SPAN)) |-> reset_seen);
  p_done_follows_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tx_fin));
  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && (st != S_WAIT)) |=> ($stable(idx) && $stable(span_q) && busy));

endmodule

// File: rtl/dacinit_seq.sv
module dacinit_seq
  import dacinit_pkg::*;
#(
  parameter int CLK_DIV       = 2,
  parameter int RST_PULSE_CYC = 10,
  parameter int POST_RST_CYC  = 3,
  parameter int CS_GAP_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       has_rst_pin,
  input  logic [2:0] span_code,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       dac_rst,
  output logic       done,
  output logic       busy
);
  localparam int CHK_W = 16;

  logic   tx_go, tx_fin, rst_done;
  frame_t tx_word;

  dacinit_ctl #(
    .RST_PULSE_CYC(RST_PULSE_CYC),
    .POST_RST_CYC (POST_RST_CYC),
    .CS_GAP_CYC   (CS_GAP_CYC)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .has_rst_pin(has_rst_pin),
    .span_code  (span_code),
    .tx_fin     (tx_fin),
    .tx_go      (tx_go),
    .tx_word    (tx_word),
    .dac_rst    (dac_rst),
    .done       (done),
    .busy       (busy),
    .rst_done   (rst_done)
  );

  dacinit_tx #(.CLK_DIV(CLK_DIV)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (tx_go),
    .word (tx_word),
    .sclk (sclk),
    .mosi (mosi),
    .cs_n (cs_n),
    .fin  (tx_fin)
  );

  // checker state: spacing since reset and since last frame end
  logic [CHK_W-1:0] since_rst, cs_hi_cnt;
  logic             rst_seen, frame_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst  <= '0;
      cs_hi_cnt  <= '0;
      rst_seen   <= 1'b0;
      frame_seen <= 1'b0;
    end else begin
      if (rst_done)             since_rst <= '0;
      else if (since_rst != '1) since_rst <= since_rst + 1'b1;
      if (!cs_n)                cs_hi_cnt <= '0;
      else if (cs_hi_cnt != '1) cs_hi_cnt <= cs_hi_cnt + 1'b1;
      if (!busy)          rst_seen <= 1'b0;
      else if (rst_done)  rst_seen <= 1'b1;
      if (!busy)          frame_seen <= 1'b0;
      else if (tx_fin)    frame_seen <= 1'b1;
    end
  end

  p_post_reset_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && rst_seen) |-> (since_rst >= CHK_W'(POST_RST_CYC)));
  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && frame_seen) |-> (cs_hi_cnt >= CHK_W'(CS_GAP_CYC)));
  p_no_frame_in_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_rst |-> cs_n);

endmodule

// File: tb/sim_dacinit_seq.sv
module sim_dacinit_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;
  localparam int RST_PULSE  = 10;
  localparam int POST_RST   = 3;
  localparam int CS_GAP     = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, has_rst_pin = 1'b0;
  logic [2:0] span_code = 3'd0;
  logic sclk, mosi, cs_n, dac_rst, done, busy;

  dacinit_seq #(.CLK_DIV(CLK_DIV), .RST_PULSE_CYC(RST_PULSE),
                .POST_RST_CYC(POST_RST), .CS_GAP_CYC(CS_GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .has_rst_pin(has_rst_pin),
    .span_code(span_code), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .dac_rst(dac_rst), .done(done), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [23:0] expq[$];

  // monitor state
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_rst = 1'b0, prev_done = 1'b0;
  logic [23:0] cap;
  int nbits, tog, cs_hi, since_pin_fall, pin_hi, since_cs_rise;
  int frames_in_run = 0, rst_rises = 0, idle_sclk_bad = 0;
  bit timing_ok, pin_run, done_seen;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cs_hi++; since_pin_fall++; since_cs_rise++;
    if (cs_n && sclk) idle_sclk_bad++;
    if (dac_rst && !prev_rst) begin pin_hi = 1; rst_rises++; end
    else if (dac_rst) pin_hi++;
    if (!dac_rst && prev_rst) begin
      chk(pin_hi == RST_PULSE, "R2 reset pin width", pin_hi, RST_PULSE);
      since_pin_fall = 0;
    end
    if (prev_cs && !cs_n) begin
      chk(!dac_rst, "R2 no frame during reset pulse", dac_rst, 0);
      if (frames_in_run > 0)
        chk(cs_hi >= CS_GAP, "R8 cs high gap", cs_hi, CS_GAP);
      if (pin_run && frames_in_run == 0)
        chk(since_pin_fall >= POST_RST, "R4 wait after pin reset", since_pin_fall, POST_RST);
      if (!pin_run && frames_in_run == 1)
        chk(cs_hi >= POST_RST, "R4 wait after soft reset", cs_hi, POST_RST);
      nbits = 0; tog = 0; timing_ok = 1'b1; cap = '0;
    end else if (!prev_cs) begin
      tog++;
      if (sclk != prev_sclk) begin
        if (tog != CLK_DIV) timing_ok = 1'b0;
        tog = 0;
        if (sclk) begin cap = {cap[22:0], mosi}; nbits++; end
      end
      if (cs_n) begin
        chk(nbits == 24, "R6 rising edges per frame", nbits, 24);
        chk(timing_ok, "R6 sclk half period", timing_ok, 1);
        if (expq.size() == 0) chk(1'b0, "R5 unexpected frame", cap, 0);
        else begin
          logic [23:0] e;
          e = expq.pop_front();
          chk(cap == e, (e[23:16] == 8'h70) ? "R3 soft reset frame" :
                        (e[23:16] == 8'h40) ? "R7 span frame" : "R5 config frame", cap, e);
        end
        frames_in_run++;
        cs_hi = 0; since_cs_rise = 0;
      end
    end
    if (done && !prev_done) begin
      chk(since_cs_rise == 1, "R9 done one cycle after last frame", since_cs_rise, 1);
      chk(expq.size() == 0, "R7 span is the last frame", expq.size(), 0);
      chk(!busy, "R9 busy low at done", busy, 0);
      chk(rst_rises == (pin_run ? 1 : 0), "R10 reset pulses per run", rst_rises, pin_run ? 1 : 0);
      done_seen = 1'b1;
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_rst = dac_rst; prev_done = done;
  end

  task automatic run_seq(input bit pin, input logic [2:0] span, input int poke_after);
    @(negedge clk);
    if (!pin) expq.push_back(24'h701234);
    expq.push_back(24'h51FFFF);
    expq.push_back(24'h905555);
    expq.push_back(24'hA05555);
    expq.push_back(24'hC00000);
    expq.push_back(24'hD00000);
    expq.push_back(24'hB00000);
    expq.push_back({8'h40, 13'd0, span});
    frames_in_run = 0; rst_rises = 0; pin_run = pin; done_seen = 1'b0;
    has_rst_pin = pin; span_code = span; start = 1'b1;
    @(negedge clk);
    start = 1'b0; span_code = ~span;
    chk(busy && !done, "R9 busy after start", {busy, done}, 2'b10);
    if (poke_after > 0) begin
      repeat (poke_after) @(negedge clk);
      has_rst_pin = !pin; start = 1'b1;   // R10: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done_seen) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done && !busy && cs_n, "R9 done held", {done, busy, cs_n}, 3'b101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({cs_n, sclk, dac_rst, done, busy} == 5'b10000, "R1 state in reset",
        {cs_n, sclk, dac_rst, done, busy}, 5'b10000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({cs_n, sclk, dac_rst, done, busy} == 5'b10000, "R1 idle after reset",
        {cs_n, sclk, dac_rst, done, busy}, 5'b10000);
    run_seq(1'b1, 3'd3, 0);
    run_seq(1'b0, 3'd5, 0);
    run_seq(1'b1, 3'd7, 6);     // start during reset pulse
    run_seq(1'b0, 3'd0, 300);   // start mid frame stream
    run_seq(1'b0, 3'd6, 1);
    chk(idle_sclk_bad == 0, "R6 sclk idle while deselected", idle_sclk_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule